// File: doc/BRIEF.md
# Timestamp latency correction unit

This block sits between a MAC's timestamp capture logic and the store that keeps timestamps. Every captured timestamp carries a direction flag. The block adds a programmable fixed correction for that direction: one correction for ingress and one for egress. The raw timestamp is made of whole seconds, a nanoseconds word and a sub-nanosecond byte. The corrected timestamp keeps the same format and appears on the output a fixed number of cycles later.

Each correction is held as a nanoseconds word plus a sub-nanosecond byte. The top bit of the nanoseconds word marks the correction as negative. A negative correction is stored in rollover-complement form: the modulus minus the latency. The modulus is 10^9 in decimal rollover mode and 2^31 in binary rollover mode. Ingress latency is normally programmed in this negative form, so that it is subtracted. Egress latency is normally programmed as a plain positive value, so that it is added. The sum wraps at the modulus. A sum that goes below zero borrows one second, and a sum that reaches the modulus carries one second.

Top module: `ts_latency_fix`

## Requirements
- R1: A timestamp presented with `in_vld` high in one cycle appears with `out_vld` high exactly two clock cycles later, with `out_dir` equal to `in_dir`. `out_vld` is high only in that case, and back-to-back inputs come out back-to-back.
- R2: A write with `cfg_we` high stores `cfg_wdata` as follows, by the value of `cfg_sel`:
  - 0: the whole word into the ingress nanoseconds correction.
  - 1: bits 15:8 of `cfg_wdata` into the ingress sub-nanosecond correction.
  - 2: the whole word into the egress nanoseconds correction.
  - 3: bits 15:8 of `cfg_wdata` into the egress sub-nanosecond correction.
  The other bits of `cfg_wdata` are ignored on a sub-nanosecond write. Timestamps with `in_dir`=0 use the ingress pair, and timestamps with `in_dir`=1 use the egress pair.
- R3: When bit 31 of the selected nanoseconds correction is set, the correction applied is (bits 30:0 + fraction/256 − modulus). When bit 31 is clear, the correction applied is (bits 30:0 + fraction/256).
- R4: The modulus is 1,000,000,000 when `dec_mode`=1 and 2^31 when `dec_mode`=0, sampled together with the timestamp.
- R5: `out_sub` is the low 8 bits of `in_sub` + the correction fraction. A carry out of that 8-bit sum adds one to the nanoseconds.
- R6: If the corrected nanoseconds would be below zero, `out_ns` is that value plus the modulus and `out_sec` is `in_sec`−1.
- R7: If the corrected nanoseconds would be equal to or above the modulus, `out_ns` is that value minus the modulus and `out_sec` is `in_sec`+1. A result of exactly the modulus gives `out_ns`=0.
- R8: After reset, `out_vld` is low, all outputs are zero and all four correction registers are zero. With zero corrections, the output timestamp equals the input timestamp.
- R9: Seconds wrap modulo 2^32: a borrow from 0 gives 0xFFFFFFFF, and a carry from 0xFFFFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Correction register write strobe |
| cfg_sel | input | 2 | Register select (0/1 ingress ns/fraction, 2/3 egress ns/fraction) |
| cfg_wdata | input | 32 | Write data |
| dec_mode | input | 1 | 1 = decimal rollover (10^9), 0 = binary rollover (2^31) |
| in_vld | input | 1 | Raw timestamp valid |
| in_dir | input | 1 | 0 = ingress, 1 = egress |
| in_sec | input | 32 | Raw seconds |
| in_ns | input | 31 | Raw nanoseconds, below the modulus |
| in_sub | input | 8 | Raw sub-nanosecond fraction (1/256 ns) |
| out_vld | output | 1 | Corrected timestamp valid |
| out_dir | output | 1 | Direction of the corrected timestamp |
| out_sec | output | 32 | Corrected seconds |
| out_ns | output | 31 | Corrected nanoseconds |
| out_sub | output | 8 | Corrected sub-nanosecond fraction |

## Verification
The vector table pairs negative ingress corrections and positive egress corrections with raw nanoseconds in three places: well inside the range, just above zero and just below the modulus. It does this in both rollover modes, which separates the no-wrap path from the borrow and carry paths and shows which modulus is in use. Results that land exactly on the modulus check the boundary of the comparison. Seconds values of 0 and 0xFFFFFFFF check that the seconds wrap. Fraction pairs with and without a byte overflow check the carry into nanoseconds. Directed tests run back-to-back inputs of opposite direction to check register selection and pipelining. One directed test writes a sub-nanosecond register with junk outside bits 15:8, to check that the field is taken from the right bits.

// File: rtl/ts_latency_fix.sv
module ts_latency_fix #(
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned NS_W     = 31,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned FRAC_LSB = 8,
  parameter int unsigned DEC_MOD  = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [NS_W:0]     cfg_wdata,
  input  logic              dec_mode,
  input  logic              in_vld,
  input  logic              in_dir,
  input  logic [SEC_W-1:0]  in_sec,
  input  logic [NS_W-1:0]   in_ns,
  input  logic [FRAC_W-1:0] in_sub,
  output logic              out_vld,
  output logic              out_dir,
  output logic [SEC_W-1:0]  out_sec,
  output logic [NS_W-1:0]   out_ns,
  output logic [FRAC_W-1:0] out_sub
);
  localparam int unsigned TW = NS_W + 1;
  localparam logic [TW-1:0] MOD_DEC = TW'(DEC_MOD);
  localparam logic [TW-1:0] MOD_BIN = {1'b1, {NS_W{1'b0}}};

  logic [TW-1:0]     ing_ns, egr_ns;
  logic [FRAC_W-1:0] ing_fr, egr_fr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ing_ns <= '0;
      egr_ns <= '0;
      ing_fr <= '0;
      egr_fr <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: ing_ns <= cfg_wdata;
        2'd1: ing_fr <= cfg_wdata[FRAC_LSB +: FRAC_W];
        2'd2: egr_ns <= cfg_wdata;
        default: egr_fr <= cfg_wdata[FRAC_LSB +: FRAC_W];
      endcase
    end
  end

  logic [TW-1:0]     sel_ns;
  logic [FRAC_W-1:0] sel_fr;
  logic [FRAC_W:0]   fr_sum;
  logic [TW-1:0]     ns_sum;

  assign sel_ns = in_dir ? egr_ns : ing_ns;
  assign sel_fr = in_dir ? egr_fr : ing_fr;
  assign fr_sum = {1'b0, in_sub} + {1'b0, sel_fr};
  assign ns_sum = {1'b0, in_ns} + {1'b0, sel_ns[NS_W-1:0]} + TW'(fr_sum[FRAC_W]);

  logic              s1_vld, s1_dir, s1_neg;
  logic [SEC_W-1:0]  s1_sec;
  logic [TW-1:0]     s1_sum, s1_mod;
  logic [FRAC_W-1:0] s1_fr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_dir <= 1'b0;
      s1_neg <= 1'b0;
      s1_sec <= '0;
      s1_sum <= '0;
      s1_mod <= MOD_BIN;
      s1_fr  <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_dir <= in_dir;
        s1_neg <= sel_ns[NS_W];
        s1_sec <= in_sec;
        s1_sum <= ns_sum;
        s1_mod <= dec_mode ? MOD_DEC : MOD_BIN;
        s1_fr  <= fr_sum[FRAC_W-1:0];
      end
    end
  end

  logic              at_or_over;
  logic [TW-1:0]     wrapped;
  logic [SEC_W-1:0]  sec_adj;

  assign at_or_over = s1_sum >= s1_mod;
  assign wrapped    = at_or_over ? s1_sum - s1_mod : s1_sum;
  assign sec_adj    = (at_or_over && !s1_neg) ? s1_sec + SEC_W'(1) :
                      (!at_or_over && s1_neg) ? s1_sec - SEC_W'(1) : s1_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_dir <= 1'b0;
      out_sec <= '0;
      out_ns  <= '0;
      out_sub <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_dir <= s1_dir;
        out_sec <= sec_adj;
        out_ns  <= wrapped[NS_W-1:0];
        out_sub <= s1_fr;
      end
    end
  end
endmodule

module ts_latency_fix_chk #(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 31,
  parameter int unsigned DEC_MOD = 1000000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             in_dir,
  input logic [SEC_W-1:0] in_sec,
  input logic             dec_mode,
  input logic             out_vld,
  input logic             out_dir,
  input logic [SEC_W-1:0] out_sec,
  input logic [NS_W-1:0]  out_ns
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 out_vld);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));

  a_r1_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_dir == $past(in_dir, 2));

  a_r4_dec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(dec_mode, 2)) |-> out_ns < NS_W'(DEC_MOD));

  a_r6_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_sec == $past(in_sec, 2)) ||
                (out_sec == $past(in_sec, 2) + SEC_W'(1)) ||
                (out_sec == $past(in_sec, 2) - SEC_W'(1)));
endmodule

bind ts_latency_fix ts_latency_fix_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .DEC_MOD(DEC_MOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dir(in_dir),
  .in_sec(in_sec), .dec_mode(dec_mode), .out_vld(out_vld),
  .out_dir(out_dir), .out_sec(out_sec), .out_ns(out_ns)
);

// File: tb/ts_latency_fix_bench.sv
module ts_latency_fix_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_mode = 1'b1;
  logic        in_vld = 1'b0;
  logic        in_dir = 1'b0;
  logic [31:0] in_sec = '0;
  logic [30:0] in_ns = '0;
  logic [7:0]  in_sub = '0;
  logic        out_vld, out_dir;
  logic [31:0] out_sec;
  logic [30:0] out_ns;
  logic [7:0]  out_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_latency_fix u_ts_latency_fix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dec_mode(dec_mode), .in_vld(in_vld),
    .in_dir(in_dir), .in_sec(in_sec), .in_ns(in_ns), .in_sub(in_sub),
    .out_vld(out_vld), .out_dir(out_dir), .out_sec(out_sec),
    .out_ns(out_ns), .out_sub(out_sub)
  );

  typedef struct packed {
    logic        dir;
    logic        dec;
    logic [31:0] cns;
    logic [7:0]  cfr;
    logic [31:0] sec;
    logic [30:0] ns;
    logic [7:0]  sub;
    logic [31:0] esec;
    logic [30:0] ens;
    logic [7:0]  efr;
  } vec_t;

  localparam logic [31:0] IN100D  = {1'b1, 31'd999999900};
  localparam logic [31:0] IN100B  = {1'b1, 31'h7FFFFF9C};
  localparam logic [31:0] IN10025 = {1'b1, 31'd999999899};
  localparam logic [31:0] EG250   = 32'd250;
  localparam int NV = 13;

  // R3 R4 R5 R6 R7 R9 cases
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, IN100D, 8'h00, 32'd5, 31'd500, 8'h00, 32'd5, 31'd400, 8'h00},
    '{1'b0, 1'b1, IN100D, 8'h00, 32'd5, 31'd30, 8'h00, 32'd4, 31'd999999930, 8'h00},
    '{1'b1, 1'b1, EG250, 8'h80, 32'd7, 31'd999999900, 8'h90, 32'd8, 31'd151, 8'h10},
    '{1'b1, 1'b1, EG250, 8'h80, 32'd7, 31'd1000, 8'h10, 32'd7, 31'd1250, 8'h90},
    '{1'b0, 1'b0, IN100B, 8'h00, 32'd10, 31'd40, 8'h00, 32'd9, 31'h7FFFFFC4, 8'h00},
    '{1'b0, 1'b0, IN100B, 8'h00, 32'd10, 31'd1000, 8'h00, 32'd10, 31'd900, 8'h00},
    '{1'b1, 1'b0, 32'h10, 8'h00, 32'd3, 31'h7FFFFFF8, 8'h00, 32'd4, 31'd8, 8'h00},
    '{1'b0, 1'b1, IN10025, 8'hC0, 32'd2, 31'd1000, 8'h00, 32'd2, 31'd899, 8'hC0},
    '{1'b0, 1'b1, IN100D, 8'h00, 32'd0, 31'd30, 8'h00, 32'hFFFFFFFF, 31'd999999930, 8'h00},
    '{1'b1, 1'b1, EG250, 8'h00, 32'hFFFFFFFF, 31'd999999800, 8'h00, 32'd0, 31'd50, 8'h00},
    '{1'b0, 1'b1, IN100D, 8'h00, 32'd6, 31'd100, 8'h00, 32'd6, 31'd0, 8'h00},
    '{1'b1, 1'b1, EG250, 8'h00, 32'd6, 31'd999999750, 8'h00, 32'd7, 31'd0, 8'h00},
    '{1'b0, 1'b1, IN10025, 8'hC0, 32'd2, 31'd1000, 8'h40, 32'd2, 31'd900, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic dir, input logic dec, input logic [31:0] sec,
                       input logic [30:0] ns, input logic [7:0] sub);
    in_vld = 1'b1; in_dir = dir; dec_mode = dec; in_sec = sec; in_ns = ns; in_sub = sub;
  endtask

  task automatic expect_out(input string req, input logic dir, input logic [31:0] sec,
                            input logic [30:0] ns, input logic [7:0] sub);
    chk({req, " out_vld"}, 64'(out_vld), 64'd1);
    chk({req, " out_dir"}, 64'(out_dir), 64'(dir));
    chk({req, " out_sec"}, 64'(out_sec), 64'(sec));
    chk({req, " out_ns"},  64'(out_ns),  64'(ns));
    chk({req, " out_sub"}, 64'(out_sub), 64'(sub));
  endtask

  task automatic fire(input string req, input logic dir, input logic dec,
                      input logic [31:0] sec, input logic [30:0] ns, input logic [7:0] sub,
                      input logic [31:0] esec, input logic [30:0] ens, input logic [7:0] efr);
    @(negedge clk);
    drive(dir, dec, sec, ns, sub);
    @(negedge clk);
    in_vld = 1'b0;
    chk({req, " R1 no early out_vld"}, 64'(out_vld), 64'd0);
    @(negedge clk);
    expect_out(req, dir, esec, ens, efr);
    @(negedge clk);
    chk({req, " R1 single pulse"}, 64'(out_vld), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_vld", 64'(out_vld), 64'd0);
    chk("R8 reset out_sec", 64'(out_sec), 64'd0);
    chk("R8 reset out_ns", 64'(out_ns), 64'd0);
    rst_n = 1'b1;

    fire("R8 zero correction ingress", 1'b0, 1'b1, 32'd9, 31'd123, 8'h55, 32'd9, 31'd123, 8'h55);
    fire("R8 zero correction egress", 1'b1, 1'b0, 32'd9, 31'h7FFFFFFF, 8'hFF, 32'd9, 31'h7FFFFFFF, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      wreg(VEC[i].dir ? 2'd2 : 2'd0, VEC[i].cns);
      wreg(VEC[i].dir ? 2'd3 : 2'd1, {16'h0, VEC[i].cfr, 8'h00});
      fire($sformatf("R3 R4 R5 R6 R7 R9 vec %0d", i), VEC[i].dir, VEC[i].dec,
           VEC[i].sec, VEC[i].ns, VEC[i].sub, VEC[i].esec, VEC[i].ens, VEC[i].efr);
    end

    // R2: separate register pairs per direction, fraction taken from bits 15:8
    wreg(2'd0, IN100D);
    wreg(2'd1, 32'hFFFF_00FF);
    wreg(2'd2, EG250);
    wreg(2'd3, 32'h0000_2000);
    @(negedge clk);
    drive(1'b1, 1'b1, 32'd1, 31'd1000, 8'h00);
    @(negedge clk);
    drive(1'b0, 1'b1, 32'd1, 31'd1000, 8'h00);
    @(negedge clk);
    in_vld = 1'b0;
    expect_out("R2 R1 egress pair", 1'b1, 32'd1, 31'd1250, 8'h20);
    @(negedge clk);
    expect_out("R2 R1 ingress pair", 1'b0, 32'd1, 31'd900, 8'h00);
    @(negedge clk);
    chk("R1 burst end", 64'(out_vld), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule